// File: doc/BRIEF.md
# Interrupt Combiner and Priority Mapper

This block collects up to 128 interrupt events and presents one request to a processor core with sixteen priority levels. Level 0 is reset, level 1 is the non-maskable interrupt, and levels 2 and 3 are reserved. The twelve levels 4 to 15 are driven from this block. Level 4 is the most urgent and level 15 the least. Every event input sets a sticky flag when it rises. Four combiners each OR the unmasked flags of a 32-event group into one line. Event numbers 0 to 3 stand for those four combiner outputs and are not real inputs.

Twelve selector slots decide what drives each external level. Slot s drives level 4+s. A slot can name a combiner (source 0 to 3) or route a single event (source 4 to 127) straight to its level. An event that is routed straight to a level leaves its combiner. The block registers the most urgent pending level as a valid flag plus a level number.

A small write-only register port sets the mask words, clears flags and loads the selector slots. A separate acknowledge input clears the flag of the event routed straight to the acknowledged level.

Top module: `irq_route`

## Requirements
- R1: After reset, `irq_valid` is 0, every mask bit is 1 (blocking), every flag is clear and every selector slot is disabled.
- R2: A 0-to-1 change on `evt_in[e]` for e in 4..127 sets flag e, and the flag stays set after the input falls. Inputs 0..3 never set a flag. An input that stays high does not set its flag again after the flag is cleared.
- R3: A write to address 4+w (w = 0..3) clears flag 32w+i for every bit i of `reg_wdata` that is 1. Bits that are 0 leave their flags unchanged.
- R4: A write to address w (w = 0..3) loads mask bits for events 32w..32w+31, with bit i for event 32w+i. A mask bit of 1 keeps its flag out of combiner w. Combiner k is the OR of its unmasked flags.
- R5: A write to address 16+s (s = 0..11) loads slot s, which drives level 4+s. In the data, bit 7 is the enable and bits 6:0 are the source. A source of 0..3 selects that combiner, and a source of 4..127 selects that event's flag directly, with no mask applied.
- R6: An event named by an enabled slot with a source of 4 or more is left out of its combiner.
- R7: `irq_valid` is 1 when any level is pending. `irq_level` then gives the numerically lowest pending level in 4..15. The outputs are registered one clock after the state that causes them.
- R8: When `ack_vld` is 1 with `ack_lvl` = L, the flag of the event routed directly to level L is cleared. If level L is fed by a combiner or its slot is disabled, the acknowledge has no effect.
- R9: A disabled slot never makes its level pending.
- R10: If a rising edge and a clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 128 | Event inputs; bits 0..3 unused |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (mask 0..3, clear 4..7, slots 16..27) |
| reg_wdata | input | 32 | Register write data |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_lvl | input | 4 | Level being acknowledged |
| irq_valid | output | 1 | A level 4..15 is pending |
| irq_level | output | 4 | Most urgent pending level |

## Verification
An event edge driven before clock edge N sets its flag at N, and the output shows it after edge N+1. A mask write, slot write, clear or acknowledge takes effect at its own edge, and the output follows one edge later. Each bench task drives inputs on the falling edge and holds a strobe for exactly one rising edge. It then waits one more falling edge before sampling, which puts every check half a cycle after the edge on which its result is due. The set-wins case drives the edge and the clear in the same half cycle so that both land on one edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    parameter int NUM_EVT   = 128;
    parameter int NUM_COMB  = 4;
    parameter int COMB_W    = NUM_EVT / NUM_COMB;
    parameter int NUM_SLOT  = 12;
    parameter int FIRST_LVL = 4;
    parameter int LVL_W     = 4;
    parameter int SRC_W     = $clog2(NUM_EVT);
    parameter int DATA_W    = 32;
    parameter int ADDR_W    = 6;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } slot_cfg_t;
endpackage

// File: rtl/irq_route_flags.sv
module irq_route_flags
    import irq_route_pkg::*;
#(
    parameter int N_EVT  = NUM_EVT,
    parameter int N_COMB = NUM_COMB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_in,
    input  logic [N_EVT-1:0] clr_vec,
    output logic [N_EVT-1:0] flags,
    output logic [N_EVT-1:0] rise_vec
);
    // low indices name combiner outputs, so they never hold a flag
    localparam logic [N_EVT-1:0] LIVE = {{(N_EVT-N_COMB){1'b1}}, {N_COMB{1'b0}}};

    logic [N_EVT-1:0] evt_q;

    assign rise_vec = evt_in & ~evt_q & LIVE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            flags <= '0;
        end else begin
            evt_q <= evt_in;
            // a new edge outranks a clear in the same cycle
            flags <= ((flags & ~clr_vec) | rise_vec) & LIVE;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic                          ack_vld,
    input  logic [LVL_W-1:0]              ack_lvl,
    output logic [NUM_EVT-1:0]            mask,
    output slot_cfg_t [NUM_SLOT-1:0]      slots,
    output logic [NUM_EVT-1:0]            clr_vec
);
    localparam int WORDS  = NUM_EVT / DATA_W;
    localparam int WIDX_W = $clog2(WORDS);

    logic              grp_word;
    logic              mask_hit;
    logic              clr_hit;
    logic              slot_hit;
    logic [WIDX_W-1:0] widx;
    logic [3:0]        sidx;
    logic [LVL_W-1:0]  ack_slot;

    assign grp_word = reg_addr[5:4] == 2'd0;
    assign widx     = reg_addr[WIDX_W-1:0];
    assign sidx     = reg_addr[3:0];
    assign mask_hit = reg_we && grp_word && (reg_addr[3:2] == 2'd0);
    assign clr_hit  = reg_we && grp_word && (reg_addr[3:2] == 2'd1);
    assign slot_hit = reg_we && (reg_addr[5:4] == 2'd1) && (int'(sidx) < NUM_SLOT);
    assign ack_slot = ack_lvl - LVL_W'(FIRST_LVL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '1;
            slots <= '0;
        end else begin
            if (mask_hit)
                mask[int'(widx)*DATA_W +: DATA_W] <= reg_wdata;
            if (slot_hit)
                slots[sidx] <= slot_cfg_t'(reg_wdata[SRC_W:0]);
        end
    end

    always_comb begin
        clr_vec = '0;
        if (clr_hit)
            clr_vec[int'(widx)*DATA_W +: DATA_W] = reg_wdata;
        if (ack_vld && (int'(ack_lvl) >= FIRST_LVL)
                    && (int'(ack_lvl) < FIRST_LVL + NUM_SLOT)) begin
            if (slots[ack_slot].en && (int'(slots[ack_slot].src) >= NUM_COMB))
                clr_vec[slots[ack_slot].src] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_route_comb.sv
module irq_route_comb
    import irq_route_pkg::*;
(
    input  logic [NUM_EVT-1:0]       flags,
    input  logic [NUM_EVT-1:0]       mask,
    input  slot_cfg_t [NUM_SLOT-1:0] slots,
    output logic [NUM_COMB-1:0]      comb_out
);
    logic [NUM_EVT-1:0] routed;

    // events taken by a direct slot are withdrawn from their group
    always_comb begin
        routed = '0;
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (slots[s].en && (int'(slots[s].src) >= NUM_COMB))
                routed[slots[s].src] = 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_COMB; k++) begin : g_group
        assign comb_out[k] = |(flags[k*COMB_W +: COMB_W]
                             & ~mask[k*COMB_W +: COMB_W]
                             & ~routed[k*COMB_W +: COMB_W]);
    end
endmodule

// File: rtl/irq_route_select.sv
module irq_route_select
    import irq_route_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EVT-1:0]       flags,
    input  logic [NUM_COMB-1:0]      comb_out,
    input  slot_cfg_t [NUM_SLOT-1:0] slots,
    output logic [NUM_SLOT-1:0]      pending,
    output logic                     irq_valid,
    output logic [LVL_W-1:0]         irq_level
);
    localparam int CIDX_W = $clog2(NUM_COMB);

    logic             nxt_vld;
    logic [LVL_W-1:0] nxt_lvl;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        always_comb begin
            if (!slots[s].en)
                pending[s] = 1'b0;
            else if (int'(slots[s].src) < NUM_COMB)
                pending[s] = comb_out[slots[s].src[CIDX_W-1:0]];
            else
                pending[s] = flags[slots[s].src];
        end
    end

    // scan from least to most urgent so the lowest slot wins
    always_comb begin
        nxt_vld = 1'b0;
        nxt_lvl = '0;
        for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (pending[s]) begin
                nxt_vld = 1'b1;
                nxt_lvl = LVL_W'(FIRST_LVL + s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_level <= '0;
        end else begin
            irq_valid <= nxt_vld;
            irq_level <= nxt_lvl;
        end
    end
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   evt_in,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 ack_vld,
    input  logic [LVL_W-1:0]     ack_lvl,
    output logic                 irq_valid,
    output logic [LVL_W-1:0]     irq_level
);
    logic [NUM_EVT-1:0]       flags;
    logic [NUM_EVT-1:0]       rise_vec;
    logic [NUM_EVT-1:0]       clr_vec;
    logic [NUM_EVT-1:0]       mask;
    slot_cfg_t [NUM_SLOT-1:0] slots;
    logic [NUM_COMB-1:0]      comb_out;
    logic [NUM_SLOT-1:0]      pending;
    logic [NUM_SLOT-1:0]      slot_en;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_en
        assign slot_en[s] = slots[s].en;
    end

    irq_route_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .clr_vec  (clr_vec),
        .flags    (flags),
        .rise_vec (rise_vec)
    );

    irq_route_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ack_vld   (ack_vld),
        .ack_lvl   (ack_lvl),
        .mask      (mask),
        .slots     (slots),
        .clr_vec   (clr_vec)
    );

    irq_route_comb u_comb (
        .flags    (flags),
        .mask     (mask),
        .slots    (slots),
        .comb_out (comb_out)
    );

    irq_route_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .comb_out  (comb_out),
        .slots     (slots),
        .pending   (pending),
        .irq_valid (irq_valid),
        .irq_level (irq_level)
    );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                irq_valid,
    input logic [LVL_W-1:0]    irq_level,
    input logic [NUM_EVT-1:0]  flags,
    input logic [NUM_EVT-1:0]  rise_vec,
    input logic [NUM_EVT-1:0]  clr_vec,
    input logic [NUM_SLOT-1:0] pending,
    input logic [NUM_SLOT-1:0] slot_en
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq_valid); // R1

    AST_FLAG_SET_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(rise_vec)) == '0); // R2

    AST_FLAG_DROP_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags) & ~flags & ~$past(clr_vec)) == '0); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rise_vec) & ~flags) == '0); // R10

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_level) >= FIRST_LVL
                       && int'(irq_level) < FIRST_LVL + NUM_SLOT)); // R7

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid == $past(|pending)); // R7

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~slot_en) == '0); // R9
endmodule

bind irq_route irq_route_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid),
    .irq_level (irq_level),
    .flags     (flags),
    .rise_vec  (rise_vec),
    .clr_vec   (clr_vec),
    .pending   (pending),
    .slot_en   (slot_en)
);

// File: tb/irq_route_test.sv
module irq_route_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt_in = '0;
    logic         reg_we = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic         ack_vld = 1'b0;
    logic [3:0]   ack_lvl = '0;
    logic         irq_valid;
    logic [3:0]   irq_level;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_route uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ack_vld   (ack_vld),
        .ack_lvl   (ack_lvl),
        .irq_valid (irq_valid),
        .irq_level (irq_level)
    );

    task automatic expect_irq(input logic v, input int lvl, input string req);
        total++;
        if (irq_valid !== v || (v && int'(irq_level) != lvl)) begin
            bad++;
            $display("FAIL %s: valid=%0b level=%0d expected valid=%0b level=%0d",
                     req, irq_valid, irq_level, v, lvl);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ack(input int lvl);
        @(negedge clk);
        ack_vld = 1'b1; ack_lvl = 4'(lvl);
        @(negedge clk);
        ack_vld = 1'b0;
    endtask

    task automatic pulse(input int e);
        @(negedge clk);
        evt_in[e] = 1'b1;
        @(negedge clk);
        evt_in[e] = 1'b0;
    endtask

    task automatic t_reset();
        settle(); expect_irq(1'b0, 0, "R1 reset");
        pulse(40); settle(); expect_irq(1'b0, 0, "R9 slots disabled after reset");
    endtask

    task automatic t_direct();
        wr(16 + 3, 32'h80 | 40); settle(); expect_irq(1'b1, 7, "R5 direct slot, R2 sticky");
        ack(7); settle(); expect_irq(1'b0, 0, "R8 ack clears direct flag");
    endtask

    task automatic t_combiner();
        wr(16 + 11, 32'h81);
        pulse(50); settle(); expect_irq(1'b0, 0, "R4 masked flag blocked");
        wr(1, ~(32'd1 << 18)); settle(); expect_irq(1'b1, 15, "R4 unmasked combiner");
        ack(15); settle(); expect_irq(1'b1, 15, "R8 ack of combiner level ignored");
        wr(4 + 1, 32'd1 << 3); settle(); expect_irq(1'b1, 15, "R3 zero bits keep flag");
        wr(4 + 1, 32'd1 << 18); settle(); expect_irq(1'b0, 0, "R3 clear one bit");
    endtask

    task automatic t_priority();
        pulse(50); pulse(40); settle(); expect_irq(1'b1, 7, "R7 lowest level wins");
        ack(7); settle(); expect_irq(1'b1, 15, "R7 next level after ack");
        wr(4 + 1, 32'd1 << 18); settle(); expect_irq(1'b0, 0, "R7 none pending");
    endtask

    task automatic t_exclusion();
        wr(16 + 0, 32'h81);
        wr(16 + 10, 32'h80 | 45);
        wr(1, 32'hFFFB_DFFF);
        pulse(45); settle(); expect_irq(1'b1, 14, "R6 routed event out of combiner");
        wr(16 + 10, 32'h0); settle(); expect_irq(1'b1, 4, "R6 unrouted event rejoins, R9");
        wr(4 + 1, 32'd1 << 13); settle(); expect_irq(1'b0, 0, "R3 clear event 45");
    endtask

    task automatic t_low_group();
        wr(16 + 5, 32'h80);
        wr(0, 32'hFFFF_FFDF);
        pulse(5); settle(); expect_irq(1'b1, 9, "R4 combiner 0 on level 9");
        wr(4 + 0, 32'd1 << 5); settle(); expect_irq(1'b0, 0, "R3 clear event 5");
        wr(0, 32'h0);
        pulse(2); settle(); expect_irq(1'b0, 0, "R2 input 2 sets no flag");
    endtask

    task automatic t_set_wins();
        wr(1, 32'hEFFB_DFFF);
        @(negedge clk);
        evt_in[60] = 1'b1;
        reg_we = 1'b1; reg_addr = 6'd5; reg_wdata = 32'd1 << 28;
        @(negedge clk);
        reg_we = 1'b0;
        settle(); expect_irq(1'b1, 4, "R10 edge beats clear");
        wr(4 + 1, 32'd1 << 28); settle(); expect_irq(1'b0, 0, "R3 clear held event");
        repeat (3) @(negedge clk);
        expect_irq(1'b0, 0, "R2 held input no re-set");
        evt_in[60] = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_combiner();
        t_priority();
        t_exclusion();
        t_low_group();
        t_set_wins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule